// File: doc/BRIEF.md
# Dual-Output Add-Subtract Unit

This arithmetic building block takes two signed operands. From the same pair it forms the sum and the difference in one cycle, and it presents both through a single register stage.

A scheme input chooses how an out-of-range result is handled:
- wrap-around in two's complement,
- clamping to the largest or smallest representable value,
- widening, which makes the result one bit wider so that it is always exact.

A packed input switches the unit to sub-word operation. Each operand word then holds two half-width lanes. The upper lanes are added and the lower lanes are subtracted. The two lane results are packed back into one output word.

Two sticky flags record whenever a result had to be wrapped or clamped. A clear input resets them.

The unit suits datapaths that need a butterfly-style sum/difference pair. It also suits datapaths that want two independent half-width operations in one issue slot. Operands are always signed, and the operand width is a parameter (8, 16 or 32 bits).

Top module: `dual_addsub`

## Requirements
- R1: When `in_valid` is high and `packed_en` is low, the next rising clock edge loads `sum_out` with X+Y and `diff_out` with X−Y. Both results are formed from the same sampled operands.
- R2: Scheme code 2'b00 (wrap) produces the low DATA_W bits of the exact result, sign-extended to the output width. Code 2'b11 behaves identically.
- R3: Scheme code 2'b01 (clamp) produces the exact result when it fits DATA_W signed bits. A positive overflow gives 2^(DATA_W−1)−1 and a negative overflow gives −2^(DATA_W−1), both sign-extended to the output width.
- R4: Scheme code 2'b10 (widen) produces the exact DATA_W+1-bit signed result, sign-extended to the output width. For 16-bit operands the result is therefore 17 bits.
- R5: With `packed_en` high, the upper lane of `sum_out` is derived from x[DATA_W−1:H] + y[DATA_W−1:H], and the lower lane from x[H−1:0] − y[H−1:0], where H = DATA_W/2. For wrap and clamp, the upper lane sits in `sum_out[DATA_W−1:H]`, the lower lane in `sum_out[H−1:0]`, and the top two bits are 0. For widen, `sum_out` = {upper lane H+1 bits, lower lane H+1 bits}. `diff_out` is 0 in packed mode.
- R6: In packed mode the selected scheme is applied to each lane on its own, at the H-bit lane width. Overflow in one lane does not alter the other lane.
- R7: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `sum_out` and `diff_out` keep their values.
- R8: `ovf_sum` is set on an accepted input whose addition overflows DATA_W bits (in packed mode, whose upper lane overflows H bits) under wrap or clamp. `ovf_diff` is set in the same way by the subtraction (in packed mode, by the lower lane). Both flags stay set until cleared. The widen scheme never sets them.
- R9: `flag_clr` high clears both flags at the next edge, even if an overflow occurs in that same cycle.
- R10: Reset (`rst_n` low, asynchronous) clears `out_valid`, `sum_out`, `diff_out` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| scheme | input | 2 | Overflow scheme: 00 wrap, 01 clamp, 10 widen, 11 wrap |
| packed_en | input | 1 | Selects two-lane packed operation |
| flag_clr | input | 1 | Clears both sticky overflow flags |
| x_in | input | DATA_W | First signed operand |
| y_in | input | DATA_W | Second signed operand |
| out_valid | output | 1 | Results are valid |
| sum_out | output | DATA_W+2 | Sum (unpacked) or packed lane result |
| diff_out | output | DATA_W+2 | Difference (unpacked), zero when packed |
| ovf_sum | output | 1 | Sticky overflow flag for sum / upper lane |
| ovf_diff | output | 1 | Sticky overflow flag for difference / lower lane |

## Verification
Every result, `out_valid` and both flags become due at the first rising edge after the operands are presented. This is the single register stage.

The bench drives each stimulus on a falling edge and samples one time unit after the following rising edge. It compares there against reference values computed from the operands just driven.

Cycles with `in_valid` low are checked at the same point against the previously expected outputs, to confirm the hold behaviour. The flag model is advanced at the same edge, with clear taking priority, so a clear and an overflow in one cycle are judged in the cycle they land.

// File: rtl/dual_addsub_pkg.sv
package dual_addsub_pkg;

    typedef enum logic [1:0] {
        OVF_WRAP  = 2'b00,
        OVF_CLAMP = 2'b01,
        OVF_WIDEN = 2'b10,
        OVF_RSVD  = 2'b11
    } ovf_scheme_e;

endpackage

// File: rtl/addsub_lane.sv
module addsub_lane
    import dual_addsub_pkg::*;
#(
    parameter int W        = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  ovf_scheme_e  scheme_i,
    output logic [W:0]   res_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   exact;
    logic [W-1:0] clamped;

    generate
        if (SUBTRACT) begin : g_sub
            assign exact = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        end else begin : g_add
            assign exact = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        end
    endgenerate

    assign ovf_o = exact[W] ^ exact[W-1];

    always_comb begin
        clamped = exact[W-1:0];
        if (ovf_o) begin
            clamped = exact[W] ? MIN_V : MAX_V;
        end
    end

    always_comb begin
        unique case (scheme_i)
            OVF_CLAMP: res_o = {clamped[W-1], clamped};
            OVF_WIDEN: res_o = exact;
            default:   res_o = {exact[W-1], exact[W-1:0]};
        endcase
    end

endmodule

// File: rtl/dual_addsub.sv
module dual_addsub
    import dual_addsub_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        scheme,
    input  logic              packed_en,
    input  logic              flag_clr,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    output logic              out_valid,
    output logic [DATA_W+1:0] sum_out,
    output logic [DATA_W+1:0] diff_out,
    output logic              ovf_sum,
    output logic              ovf_diff
);

    localparam int HALF_W = DATA_W / 2;
    localparam int OUT_W  = DATA_W + 2;

    ovf_scheme_e sch;
    assign sch = ovf_scheme_e'(scheme);

    logic [DATA_W:0] full_sum, full_diff;
    logic            full_sum_ovf, full_diff_ovf;
    logic [HALF_W:0] hi_sum, lo_diff;
    logic            hi_ovf, lo_ovf;

    addsub_lane #(.W(DATA_W), .SUBTRACT(1'b0)) u_full_add (
        .a_i(x_in), .b_i(y_in), .scheme_i(sch), .res_o(full_sum), .ovf_o(full_sum_ovf)
    );
    addsub_lane #(.W(DATA_W), .SUBTRACT(1'b1)) u_full_sub (
        .a_i(x_in), .b_i(y_in), .scheme_i(sch), .res_o(full_diff), .ovf_o(full_diff_ovf)
    );
    addsub_lane #(.W(HALF_W), .SUBTRACT(1'b0)) u_hi_add (
        .a_i(x_in[DATA_W-1:HALF_W]), .b_i(y_in[DATA_W-1:HALF_W]), .scheme_i(sch),
        .res_o(hi_sum), .ovf_o(hi_ovf)
    );
    addsub_lane #(.W(HALF_W), .SUBTRACT(1'b1)) u_lo_sub (
        .a_i(x_in[HALF_W-1:0]), .b_i(y_in[HALF_W-1:0]), .scheme_i(sch),
        .res_o(lo_diff), .ovf_o(lo_ovf)
    );

    logic [OUT_W-1:0] nxt_sum, nxt_diff;
    logic             set_s, set_d;
    logic             widen;

    assign widen = (sch == OVF_WIDEN);

    always_comb begin
        if (packed_en) begin
            nxt_diff = '0;
            if (widen) begin
                nxt_sum = {hi_sum, lo_diff};
            end else begin
                nxt_sum = {2'b00, hi_sum[HALF_W-1:0], lo_diff[HALF_W-1:0]};
            end
            set_s = hi_ovf & ~widen;
            set_d = lo_ovf & ~widen;
        end else begin
            nxt_sum  = {full_sum[DATA_W], full_sum};
            nxt_diff = {full_diff[DATA_W], full_diff};
            set_s    = full_sum_ovf & ~widen;
            set_d    = full_diff_ovf & ~widen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_out   <= '0;
            diff_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_out  <= nxt_sum;
                diff_out <= nxt_diff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_sum  <= 1'b0;
            ovf_diff <= 1'b0;
        end else if (flag_clr) begin
            ovf_sum  <= 1'b0;
            ovf_diff <= 1'b0;
        end else if (in_valid) begin
            ovf_sum  <= ovf_sum | set_s;
            ovf_diff <= ovf_diff | set_d;
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sum_out) && $stable(diff_out)));
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!ovf_sum && !ovf_diff));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sum && !flag_clr) |=> ovf_sum);
    // R8
    widen_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && widen && !flag_clr && !ovf_diff) |=> !ovf_diff);
    // R5
    packed_diff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && packed_en) |=> (diff_out == '0));

endmodule

// File: tb/dual_addsub_tb.sv
module dual_addsub_tb_top;

    localparam int N  = 16;
    localparam int H  = N / 2;
    localparam int OW = N + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    scheme = 2'b00;
    logic          packed_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic [N-1:0]  x_in = '0;
    logic [N-1:0]  y_in = '0;
    logic          out_valid;
    logic [OW-1:0] sum_out, diff_out;
    logic          ovf_sum, ovf_diff;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [OW-1:0] e_sum = '0, e_diff = '0;
    bit            e_fs = 1'b0, e_fd = 1'b0;

    always #2 clk = ~clk;

    dual_addsub #(.DATA_W(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scheme(scheme),
        .packed_en(packed_en), .flag_clr(flag_clr), .x_in(x_in), .y_in(y_in),
        .out_valid(out_valid), .sum_out(sum_out), .diff_out(diff_out),
        .ovf_sum(ovf_sum), .ovf_diff(ovf_diff)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint lane_val(input longint a, input longint b, input int w,
                                        input bit sub, input int sch, output bit ov);
        longint r, mx, mn, m;
        r  = sub ? a - b : a + b;
        mx = (longint'(1) <<< (w - 1)) - 1;
        mn = -mx - 1;
        ov = (r > mx) || (r < mn);
        if (sch == 2) return r;
        if (sch == 1) return ov ? ((r > mx) ? mx : mn) : r;
        m = r & ((longint'(1) <<< w) - 1);
        if (m > mx) m = m - (longint'(1) <<< w);
        return m;
    endfunction

    task automatic step(input logic [N-1:0] x, input logic [N-1:0] y, input int sch,
                        input bit pk, input bit clr, input bit v, input string req);
        longint vs, vd;
        bit os, od;
        logic [OW-1:0] ns, nd;
        @(negedge clk);
        x_in = x; y_in = y; scheme = 2'(sch); packed_en = pk; flag_clr = clr; in_valid = v;
        if (pk) begin
            vs = lane_val(longint'($signed(x[N-1:H])), longint'($signed(y[N-1:H])), H, 1'b0, sch, os);
            vd = lane_val(longint'($signed(x[H-1:0])), longint'($signed(y[H-1:0])), H, 1'b1, sch, od);
            if (sch == 2) ns = {(H+1)'(vs), (H+1)'(vd)};
            else          ns = {2'b00, H'(vs), H'(vd)};
            nd = '0;
        end else begin
            vs = lane_val(longint'($signed(x)), longint'($signed(y)), N, 1'b0, sch, os);
            vd = lane_val(longint'($signed(x)), longint'($signed(y)), N, 1'b1, sch, od);
            ns = OW'(vs);
            nd = OW'(vd);
        end
        if (sch == 2) begin os = 1'b0; od = 1'b0; end
        @(posedge clk);
        #1;
        if (v) begin e_sum = ns; e_diff = nd; end
        if (clr) begin e_fs = 1'b0; e_fd = 1'b0; end
        else if (v) begin e_fs = e_fs | os; e_fd = e_fd | od; end
        chk(out_valid == v, {req, " R7 valid"}, out_valid, v);
        chk(sum_out == e_sum, {req, " sum"}, sum_out, e_sum);
        chk(diff_out == e_diff, {req, " diff"}, diff_out, e_diff);
        chk(ovf_sum == e_fs, {req, " R8 ovf_sum"}, ovf_sum, e_fs);
        chk(ovf_diff == e_fd, {req, " R8 ovf_diff"}, ovf_diff, e_fd);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #5;
        // R10 reset state
        chk(out_valid == 0 && sum_out == 0 && diff_out == 0, "R10 reset outputs", sum_out, 0);
        chk(ovf_sum == 0 && ovf_diff == 0, "R10 reset flags", ovf_sum, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 plain sum and difference
        step(16'd1000, 16'd250, 0, 0, 0, 1, "R1 basic");
        step(16'hFF38, 16'd57, 0, 0, 0, 1, "R1 negative");
        // R2 wrap on overflow, and reserved code behaves as wrap
        step(16'h7FFF, 16'h0001, 0, 0, 0, 1, "R2 wrap pos");
        step(16'h8000, 16'h0001, 3, 0, 1, 1, "R2 reserved+R9 clr");
        step(16'h8000, 16'h0001, 3, 0, 0, 1, "R2 reserved");
        step(16'h0, 16'h0, 0, 0, 1, 0, "R9 clear idle");
        // R3 clamp both directions
        step(16'h7FFF, 16'h7FFF, 1, 0, 0, 1, "R3 clamp pos");
        step(16'h8000, 16'h7FFF, 1, 0, 1, 1, "R3 clamp neg R9 clr priority");
        // R4 widen extremes
        step(16'h7FFF, 16'h7FFF, 2, 0, 0, 1, "R4 widen max");
        step(16'h8000, 16'h7FFF, 2, 0, 0, 1, "R4 widen min");
        // R5 R6 packed lanes
        step(16'h7F80, 16'h0101, 0, 1, 1, 1, "R5 packed wrap");
        step(16'h7F80, 16'h0101, 1, 1, 1, 1, "R6 packed clamp");
        step(16'h7F80, 16'h017F, 2, 1, 0, 1, "R5 packed widen");
        step(16'h1280, 16'h0345, 1, 1, 1, 1, "R6 lane isolation");
        // R7 hold while idle
        step(16'h1234, 16'h4321, 0, 0, 0, 0, "R7 hold");
        step(16'hAAAA, 16'h5555, 1, 1, 0, 0, "R7 hold packed");

        for (int i = 0; i < 3000; i++) begin
            step(N'($urandom), N'($urandom), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 7) != 0), "R1 R5 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule